// File: doc/BRIEF.md
# General Register File with Partial-Width Access

This block holds sixteen 64-bit general registers for an integer datapath that follows 64-bit long-mode operand rules. It has one combinational read port and one synchronous write port. Each port carries a 4-bit register number, a 2-bit operand width code and a flag that says whether the instruction carried the register-extension prefix. Register numbers 0 to 7 name A, C, D, B, SP, BP, SI and DI. Numbers 8 to 15 name R8 to R15, and only the prefix can supply that fourth bit.

A read returns the addressed slice zero-extended to 64 bits. A write merges its data into the addressed slice. A 32-bit write also clears the upper half of the register. In 8-bit mode, numbers 4 to 7 select one of two sets of registers, and the prefix flag decides which. Without the prefix they select the high bytes (bits 15:8) of registers 0 to 3. With the prefix they select the low bytes of registers 4 to 7.

Both ports are plain and have no valid/ready pairing. The write port accepts one write in every cycle that `wr_en` is high, and it never applies back-pressure. The read data is a combinational function of the current register contents. A write therefore becomes visible on the cycle after its clock edge.

Top module: `gpr_file`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all sixteen registers, so any read that follows returns 0.
- R2: When the prefix flag is 1, all four number bits index registers 0 to 15. When the flag is 0, bit 3 of the number is ignored; for example, a 64-bit read of number 12 without the prefix returns register 4.
- R3: Width codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = 64-bit. A read returns bits 7:0, 15:0, 31:0 or 63:0 of the register, zero-extended to 64 bits. The 8-bit high-byte case in R4 is the one exception.
- R4: In 8-bit mode without the prefix, numbers 4, 5, 6 and 7 address bits 15:8 of registers 0, 1, 2 and 3. This holds for both reads and writes, and a write takes its byte from `wr_data[7:0]`.
- R5: In 8-bit mode with the prefix, every number addresses bits 7:0 of the register it names. For example, number 5 is the low byte of register 5, and no high byte can be reached.
- R6: A 32-bit write loads `wr_data[31:0]` into bits 31:0 and clears bits 63:32.
- R7: An 8-bit or 16-bit write changes only the addressed byte or half-word and leaves every other bit of the register unchanged.
- R8: A 64-bit write replaces the whole register with `wr_data`.
- R9: When `wr_en` is low nothing is written. A write changes only its own destination register.
- R10: A read of the register being written in the same cycle returns the old contents. The new value appears on the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all register updates occur on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_num | input | 4 | Read register number |
| rd_width | input | 2 | Read width code (0=8, 1=16, 2=32, 3=64) |
| rd_rex | input | 1 | Read-side prefix-present flag |
| rd_data | output | 64 | Selected slice, zero-extended |
| wr_en | input | 1 | Write strobe |
| wr_num | input | 4 | Write register number |
| wr_width | input | 2 | Write width code (0=8, 1=16, 2=32, 3=64) |
| wr_rex | input | 1 | Write-side prefix-present flag |
| wr_data | input | 64 | Write data, taken from its low-order bits |

## Verification
The hardest situation to reach from the ports is a high-byte write that must leave both the low byte and bits 63:16 of its register intact. This can only be observed once those bits hold known non-zero values. The stimulus therefore first loads every register with a distinct 64-bit pattern. It then writes through the high-byte aliases and the prefixed low-byte aliases. Finally it reads back the full 64-bit registers, and also their untouched neighbours, which confirms that one alias never lands on the other set. The same-cycle read-versus-write case is reached by driving both ports on one register in a single cycle and sampling before the edge, then again after it.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  typedef enum logic [1:0] {
    OPW_8  = 2'd0,
    OPW_16 = 2'd1,
    OPW_32 = 2'd2,
    OPW_64 = 2'd3
  } opw_e;
endpackage

// File: rtl/gpr_locate.sv
// Maps a register number, width and prefix flag to a physical index and a
// flag that says the slice is bits 15:8 rather than the low end.
module gpr_locate
  import gpr_pkg::*;
#(
  parameter int NUM_W = 4
) (
  input  logic [NUM_W-1:0] num,
  input  opw_e             width,
  input  logic             rex,
  output logic [NUM_W-1:0] idx,
  output logic             hi
);
  always_comb begin
    idx = num;
    hi  = 1'b0;
    if (!rex) begin
      idx[NUM_W-1] = 1'b0;
      if (width == OPW_8 && num[2]) begin
        hi       = 1'b1;
        idx      = '0;
        idx[1:0] = num[1:0];
      end
    end
  end
endmodule

// File: rtl/gpr_merge.sv
// Builds the next register value for a partial or full write.
module gpr_merge
  import gpr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] din,
  input  opw_e            width,
  input  logic            hi,
  output logic [XLEN-1:0] nxt
);
  always_comb begin
    unique case (width)
      OPW_8:   nxt = hi ? {old_val[XLEN-1:16], din[7:0], old_val[7:0]}
                        : {old_val[XLEN-1:8], din[7:0]};
      OPW_16:  nxt = {old_val[XLEN-1:16], din[15:0]};
      OPW_32:  nxt = {{(XLEN-32){1'b0}}, din[31:0]};
      default: nxt = din;
    endcase
  end
endmodule

// File: rtl/gpr_extract.sv
// Picks the addressed slice out of a register and zero-extends it.
module gpr_extract
  import gpr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] val,
  input  opw_e            width,
  input  logic            hi,
  output logic [XLEN-1:0] dout
);
  always_comb begin
    unique case (width)
      OPW_8:   dout = {{(XLEN-8){1'b0}}, (hi ? val[15:8] : val[7:0])};
      OPW_16:  dout = {{(XLEN-16){1'b0}}, val[15:0]};
      OPW_32:  dout = {{(XLEN-32){1'b0}}, val[31:0]};
      default: dout = val;
    endcase
  end
endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_pkg::*;
#(
  parameter int NREGS = 16,
  parameter int XLEN  = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(NREGS)-1:0] rd_num,
  input  logic [1:0]               rd_width,
  input  logic                     rd_rex,
  output logic [XLEN-1:0]          rd_data,
  input  logic                     wr_en,
  input  logic [$clog2(NREGS)-1:0] wr_num,
  input  logic [1:0]               wr_width,
  input  logic                     wr_rex,
  input  logic [XLEN-1:0]          wr_data
);
  localparam int NUM_W = $clog2(NREGS);

  logic [XLEN-1:0]  regs [NREGS];
  logic [NUM_W-1:0] r_idx, w_idx;
  logic             r_hi, w_hi;
  logic [XLEN-1:0]  w_old, w_next;
  opw_e             r_w, w_w;

  assign r_w = opw_e'(rd_width);
  assign w_w = opw_e'(wr_width);

  gpr_locate #(.NUM_W(NUM_W)) u_rloc (
    .num(rd_num), .width(r_w), .rex(rd_rex), .idx(r_idx), .hi(r_hi)
  );
  gpr_locate #(.NUM_W(NUM_W)) u_wloc (
    .num(wr_num), .width(w_w), .rex(wr_rex), .idx(w_idx), .hi(w_hi)
  );

  assign w_old = regs[w_idx];

  gpr_merge #(.XLEN(XLEN)) u_merge (
    .old_val(w_old), .din(wr_data), .width(w_w), .hi(w_hi), .nxt(w_next)
  );

  gpr_extract #(.XLEN(XLEN)) u_extract (
    .val(regs[r_idx]), .width(r_w), .hi(r_hi), .dout(rd_data)
  );

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= '0;
      else if (wr_en && w_idx == NUM_W'(i))
        regs[i] <= w_next;
    end

    // R9
    others_stable_chk: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && w_idx == NUM_W'(i)) |=> $stable(regs[i]));
  end

  // R6
  dword_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && w_w == OPW_32) |=> (regs[$past(w_idx)][XLEN-1:32] == '0));

  // R7
  word_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && w_w == OPW_16) |=>
      (regs[$past(w_idx)][XLEN-1:16] == $past(w_old[XLEN-1:16])));

  // R7
  hibyte_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && w_w == OPW_8 && w_hi) |=>
      ((regs[$past(w_idx)][7:0] == $past(w_old[7:0])) &&
       (regs[$past(w_idx)][XLEN-1:16] == $past(w_old[XLEN-1:16]))));

  // R5
  rex_lowbyte_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && w_w == OPW_8 && wr_rex) |=>
      (regs[$past(wr_num)][7:0] == $past(wr_data[7:0])));
endmodule

// File: tb/test_gpr_file.sv
module test_gpr_file;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rd_num = '0;
  logic [1:0]  rd_width = 2'd3;
  logic        rd_rex = 1'b1;
  logic [63:0] rd_data;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_num = '0;
  logic [1:0]  wr_width = 2'd3;
  logic        wr_rex = 1'b1;
  logic [63:0] wr_data = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  gpr_file i_gpr_file (
    .clk(clk), .rst(rst),
    .rd_num(rd_num), .rd_width(rd_width), .rd_rex(rd_rex), .rd_data(rd_data),
    .wr_en(wr_en), .wr_num(wr_num), .wr_width(wr_width), .wr_rex(wr_rex),
    .wr_data(wr_data)
  );

  function automatic logic [63:0] pat(input int i);
    return 64'h0101010101010101 * 64'(i * 16 + 5) ^ 64'hF000_0000_0000_0000;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int n, input int w, input bit rex, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_num = 4'(n); wr_width = 2'(w); wr_rex = rex; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int n, input int w, input bit rex, output logic [63:0] d);
    rd_num = 4'(n); rd_width = 2'(w); rd_rex = rex;
    #1 d = rd_data;
  endtask

  task automatic do_reset();
    logic [63:0] v;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 16; i++) begin
      rd(i, 3, 1, v);
      check("R1 reset clears", v, 64'h0);
    end
  endtask

  task automatic t_fill();
    logic [63:0] v;
    for (int i = 0; i < 16; i++) wr(i, 3, 1, pat(i));
    for (int i = 0; i < 16; i++) begin
      rd(i, 3, 1, v);
      check("R8 full write", v, pat(i));
    end
    rd(12, 3, 0, v);
    check("R2 bit3 ignored without prefix", v, pat(4));
    rd(9, 3, 0, v);
    check("R2 bit3 ignored without prefix", v, pat(1));
  endtask

  task automatic t_read_widths();
    logic [63:0] v;
    wr(0, 3, 0, 64'h1122334455667788);
    rd(0, 0, 1, v); check("R3 8-bit read", v, 64'h88);
    rd(0, 1, 0, v); check("R3 16-bit read", v, 64'h7788);
    rd(0, 2, 0, v); check("R3 32-bit read", v, 64'h55667788);
    rd(0, 3, 0, v); check("R3 64-bit read", v, 64'h1122334455667788);
  endtask

  task automatic t_high_byte();
    logic [63:0] v;
    wr(4, 0, 0, 64'hFFFF_FFFF_FFFF_FFAB);
    rd(0, 3, 1, v); check("R4 high byte write, R7 rest kept", v, 64'h112233445566AB88);
    rd(4, 0, 0, v); check("R4 high byte read", v, 64'hAB);
    rd(4, 3, 1, v); check("R4 reg4 untouched", v, pat(4));
    rd(7, 0, 0, v); check("R4 high byte of B", v, 64'(pat(3)[15:8]));
  endtask

  task automatic t_rex_low();
    logic [63:0] v;
    wr(5, 0, 1, 64'h00000000000000CD);
    rd(5, 3, 1, v); check("R5 prefixed low byte write", v, {pat(5)[63:8], 8'hCD});
    rd(1, 3, 1, v); check("R5 C not touched", v, pat(1));
    rd(5, 0, 1, v); check("R5 prefixed low byte read", v, 64'hCD);
    rd(13, 0, 1, v); check("R5 R13 low byte", v, 64'(pat(13)[7:0]));
  endtask

  task automatic t_dword();
    logic [63:0] v;
    wr(1, 2, 0, 64'hFFFF_FFFF_DEAD_BEEF);
    rd(1, 3, 1, v); check("R6 32-bit write clears upper", v, 64'h00000000DEADBEEF);
    wr(14, 2, 1, 64'h0);
    rd(14, 3, 1, v); check("R6 32-bit zero write", v, 64'h0);
  endtask

  task automatic t_word();
    logic [63:0] v;
    wr(2, 1, 0, 64'hAAAA_AAAA_AAAA_BEEF);
    rd(2, 3, 1, v); check("R7 16-bit write keeps upper", v, {pat(2)[63:16], 16'hBEEF});
  endtask

  task automatic t_no_enable();
    logic [63:0] v;
    @(negedge clk);
    wr_en = 1'b0; wr_num = 4'd3; wr_width = 2'd3; wr_rex = 1'b1; wr_data = '1;
    @(negedge clk);
    @(negedge clk);
    rd(3, 3, 1, v); check("R9 no write without enable", v, pat(3));
    rd(6, 3, 1, v); check("R9 bystander unchanged", v, pat(6));
  endtask

  task automatic t_same_cycle();
    logic [63:0] v;
    @(negedge clk);
    wr_en = 1'b1; wr_num = 4'd10; wr_width = 2'd3; wr_rex = 1'b1; wr_data = 64'h0123456789ABCDEF;
    rd(10, 3, 1, v); check("R10 old value before edge", v, pat(10));
    @(negedge clk);
    wr_en = 1'b0;
    rd(10, 3, 1, v); check("R10 new value after edge", v, 64'h0123456789ABCDEF);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    do_reset();
    t_fill();
    t_read_widths();
    t_high_byte();
    t_rex_low();
    t_dword();
    t_word();
    t_no_enable();
    t_same_cycle();
    do_reset();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule